// File: doc/BRIEF.md
# Flash Write-Completion Poller

This block runs on the host side of a parallel flash interface. After software or another controller has issued a program or erase command to the flash, a single `start` pulse hands the poller the address that was written, the data expected there once the write is finished, and the detection mode. From then on the poller repeatedly reads that address through a request/acknowledge read port. It ends with exactly one of three single-cycle outcomes: done, error or timeout.

Two detection modes exist. In complement mode, completion is seen when bit 7 of the word read back equals bit 7 of the expected data. The caller passes 0xFFFF for an erase, so that bit is 1. In toggle mode, completion is seen when bit 6 holds the same value on two consecutive reads. Because the rest of the word is not trustworthy right away, the poller then stays quiet for a settle interval and reads the full word once. A mismatch there is not taken at face value. Two more reads of the same address decide between done and error.

Top module: `flash_poll_engine`

## Requirements
- R1: While reset is asserted and directly after it, `busy`, `done`, `error`, `timeout` and `rd_req` are all low.
- R2: A `start` pulse while idle latches address, expected data and mode, and `busy` rises on the next cycle. A `start` while `busy` is high has no effect on the address read or on the outcome.
- R3: Every read is made at the latched address. `rd_req` stays high with a stable `rd_addr` until the cycle in which `rd_ack` is high, and `rd_data` is taken in that cycle.
- R4: With `start_mode` = 0 (complement mode), a poll read completes when its bit 7 equals bit 7 of the expected data. Reads whose bit 7 differs continue the polling.
- R5: With `start_mode` = 1 (toggle mode), a poll read completes when its bit 6 equals bit 6 of the previous poll read of the same operation. The first poll read never completes, and bit 7 has no influence.
- R6: After a completing poll read, no read is requested for at least `SETTLE_CYC` cycles. Then one full-word verify read is made.
- R7: A verify read equal to the expected 16-bit data produces a `done` pulse with no further reads.
- R8: A verify read that differs triggers exactly two confirmation reads. If both equal the expected data, `done` follows. A confirmation read that differs produces `error` at once, with no further reads.
- R9: When `MAX_POLLS` poll reads have completed without detecting completion, `timeout` pulses and no further read is made.
- R10: `done`, `error` and `timeout` are single-cycle pulses, never more than one at a time, exactly one per accepted start. `busy` falls in the cycle the pulse is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin polling (accepted only when idle) |
| start_addr | input | AW | Address of the program/erase operation |
| start_data | input | 16 | Data expected once the write is complete |
| start_mode | input | 1 | 0 = bit-7 complement mode, 1 = bit-6 toggle mode |
| busy | output | 1 | High from start until the outcome pulse |
| done | output | 1 | Pulse: operation completed with correct data |
| error | output | 1 | Pulse: data confirmed wrong |
| timeout | output | 1 | Pulse: poll limit reached |
| rd_req | output | 1 | Read request, held until acknowledged |
| rd_addr | output | AW | Read address |
| rd_ack | input | 1 | Read acknowledge, data valid this cycle |
| rd_data | input | 16 | Read data |

## Verification
The bench builds the poller with `SETTLE_CYC` = 8 and `MAX_POLLS` = 6. With these values the settle gap shows up clearly against the two-cycle spacing of ordinary reads, and a timeout is reached after only six poll reads in either mode. Scripted read responses lead both modes through quick completion, delayed completion, verify mismatch with a good or bad confirmation, and timeout. The number of reads before each outcome is compared with a count derived from the requirements.

// File: rtl/flash_poll_engine.sv
module flash_poll_engine #(
  parameter int AW         = 22,
  parameter int SETTLE_CYC = 200,
  parameter int MAX_POLLS  = 4096,
  localparam int SW = $clog2(SETTLE_CYC + 1),
  localparam int PW = $clog2(MAX_POLLS + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [AW-1:0] start_addr,
  input  logic [15:0]   start_data,
  input  logic          start_mode,
  output logic          busy,
  output logic          done,
  output logic          error,
  output logic          timeout,
  output logic          rd_req,
  output logic [AW-1:0] rd_addr,
  input  logic          rd_ack,
  input  logic [15:0]   rd_data
);

  typedef enum logic [2:0] {S_IDLE, S_POLL, S_SETTLE, S_VERIFY, S_CONF} state_t;

  state_t        st;
  logic [AW-1:0] addr_q;
  logic [15:0]   exp_q;
  logic          mode_q;
  logic          prev6, have_prev, conf_second;
  logic [PW-1:0] poll_cnt;
  logic [SW-1:0] settle_cnt;
  logic          done_q, err_q, to_q;

  wire complete = mode_q ? (have_prev && (rd_data[6] == prev6))
                         : (rd_data[7] == exp_q[7]);
  wire word_ok  = (rd_data == exp_q);

  assign busy    = (st != S_IDLE);
  assign rd_req  = (st == S_POLL) || (st == S_VERIFY) || (st == S_CONF);
  assign rd_addr = addr_q;
  assign done    = done_q;
  assign error   = err_q;
  assign timeout = to_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st          <= S_IDLE;
      addr_q      <= '0;
      exp_q       <= '0;
      mode_q      <= 1'b0;
      prev6       <= 1'b0;
      have_prev   <= 1'b0;
      conf_second <= 1'b0;
      poll_cnt    <= '0;
      settle_cnt  <= '0;
      done_q      <= 1'b0;
      err_q       <= 1'b0;
      to_q        <= 1'b0;
    end else begin
      done_q <= 1'b0;
      err_q  <= 1'b0;
      to_q   <= 1'b0;
      case (st)
        S_IDLE: if (start) begin
          addr_q    <= start_addr;
          exp_q     <= start_data;
          mode_q    <= start_mode;
          have_prev <= 1'b0;
          poll_cnt  <= '0;
          st        <= S_POLL;
        end
        S_POLL: if (rd_ack) begin
          poll_cnt  <= poll_cnt + 1'b1;
          prev6     <= rd_data[6];
          have_prev <= 1'b1;
          if (complete) begin
            settle_cnt <= '0;
            st         <= S_SETTLE;
          end else if (poll_cnt == PW'(MAX_POLLS - 1)) begin
            to_q <= 1'b1;
            st   <= S_IDLE;
          end
        end
        S_SETTLE: begin
          settle_cnt <= settle_cnt + 1'b1;
          if (settle_cnt == SW'(SETTLE_CYC - 1)) st <= S_VERIFY;
        end
        S_VERIFY: if (rd_ack) begin
          if (word_ok) begin
            done_q <= 1'b1;
            st     <= S_IDLE;
          end else begin
            conf_second <= 1'b0;
            st          <= S_CONF;
          end
        end
        S_CONF: if (rd_ack) begin
          if (!word_ok) begin
            err_q <= 1'b1;
            st    <= S_IDLE;
          end else if (conf_second) begin
            done_q <= 1'b1;
            st     <= S_IDLE;
          end else begin
            conf_second <= 1'b1;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  AST_ONE_OUTCOME: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({done, error, timeout})); // R10
  AST_OUTCOME_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    (done || error || timeout) |=> !(done || error || timeout)); // R10
  AST_BUSY_ENDS_WITH_OUTCOME: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> (done || error || timeout)); // R10
  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req && !rd_ack) |=> (rd_req && $stable(rd_addr))); // R3
  AST_NO_REQ_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !rd_req); // R9
  AST_SETTLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_SETTLE) |-> !rd_req); // R6
  AST_POLL_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
    poll_cnt <= PW'(MAX_POLLS)); // R9
  AST_START_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> busy); // R2

endmodule

// File: tb/flash_poll_engine_tb.sv
`timescale 1ns/1ps
module flash_poll_engine_tb;
  localparam int AW = 22;
  localparam int SC = 8;
  localparam int MP = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [AW-1:0] start_addr = '0;
  logic [15:0] start_data = '0;
  logic start_mode = 1'b0;
  logic busy, done, error, timeout, rd_req;
  logic [AW-1:0] rd_addr;
  logic rd_ack = 1'b0;
  logic [15:0] rd_data = '0;

  always #2.5 clk = ~clk;

  flash_poll_engine #(.AW(AW), .SETTLE_CYC(SC), .MAX_POLLS(MP)) u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .start_addr(start_addr),
    .start_data(start_data), .start_mode(start_mode), .busy(busy),
    .done(done), .error(error), .timeout(timeout), .rd_req(rd_req),
    .rd_addr(rd_addr), .rd_ack(rd_ack), .rd_data(rd_data));

  typedef struct packed { logic [1:0] kind; logic [7:0] reads; } exp_t;
  exp_t sb[$];

  int n_chk = 0, n_fail = 0, cyc = 0;
  logic [15:0] script [16];
  int scr_len = 0;
  logic [15:0] dflt = '0;
  int rd_idx = 0;
  int last_ack = 0;
  int gap [32];
  logic [AW-1:0] cur_addr = '0;
  logic prev_pulse = 1'b0;

  task automatic chk(input bit ok, input string req, input longint act, input longint expv);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
    end
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
  endtask

  // read responder: one read every two cycles
  always @(negedge clk) begin
    cyc++;
    if (rd_ack) rd_ack = 1'b0;
    else if (rd_req) begin
      rd_data = (rd_idx < scr_len) ? script[rd_idx] : dflt;
      rd_ack = 1'b1;
      if (rd_idx < 32) gap[rd_idx] = cyc - last_ack;
      last_ack = cyc;
      chk(rd_addr == cur_addr, "R3 read address", rd_addr, cur_addr);
      rd_idx++;
    end
  end

  // monitor: pops expected outcomes
  always @(negedge clk) begin
    logic pulse;
    pulse = done | error | timeout;
    if (rst_n && pulse) begin
      logic [1:0] k;
      k = done ? 2'd0 : (error ? 2'd1 : 2'd2);
      chk(!prev_pulse, "R10 single-cycle pulse", 1, 0);
      chk(busy == 1'b0, "R10 busy falls with outcome", busy, 0);
      chk((done + error + timeout) == 1, "R10 one outcome", done + error + timeout, 1);
      if (sb.size() == 0) chk(0, "R10 unexpected outcome", k, 3);
      else begin
        exp_t e;
        e = sb.pop_front();
        chk(k == e.kind, "R4-R9 outcome kind", k, e.kind);
        chk(rd_idx == int'(e.reads), "R7/R8/R9 read count", rd_idx, e.reads);
      end
    end
    prev_pulse = pulse;
  end

  task automatic run(input logic [AW-1:0] a, input logic [15:0] d, input logic m,
                     input logic [1:0] kind, input int reads, input bit restart_mid);
    exp_t e;
    e.kind = kind;
    e.reads = 8'(reads);
    sb.push_back(e);
    rd_idx = 0;
    cur_addr = a;
    @(negedge clk);
    start = 1'b1; start_addr = a; start_data = d; start_mode = m;
    @(negedge clk);
    start = 1'b0;
    chk(busy == 1'b1, "R2 busy after start", busy, 1);
    if (restart_mid) begin
      repeat (3) @(negedge clk);
      start = 1'b1; start_addr = a ^ 22'h15555; start_data = ~d; start_mode = ~m;
      @(negedge clk);
      start = 1'b0;
    end
    while (busy) @(negedge clk);
    repeat (4) @(negedge clk);
    chk(sb.size() == 0, "R10 outcome produced", sb.size(), 0);
    chk(rd_req == 1'b0, "R9 no read after outcome", rd_req, 0);
  endtask

  task automatic load(input logic [15:0] w0, input logic [15:0] w1, input logic [15:0] w2,
                      input logic [15:0] w3, input logic [15:0] w4, input int len,
                      input logic [15:0] df);
    script[0] = w0; script[1] = w1; script[2] = w2; script[3] = w3; script[4] = w4;
    scr_len = len; dflt = df;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    summary();
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk({busy, done, error, timeout, rd_req} == 5'b0, "R1 outputs in reset", {busy, done, error, timeout, rd_req}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk({busy, done, error, timeout, rd_req} == 5'b0, "R1 outputs after reset", {busy, done, error, timeout, rd_req}, 0);

    // R4 program, bit7 complemented twice then true; R6 settle; R7 done
    load(16'h0080, 16'h0080, 16'h1234, 16'h0, 16'h0, 3, 16'h1234);
    run(22'h0A5A5, 16'h1234, 1'b0, 2'd0, 4, 0);
    chk(gap[3] >= SC, "R6 settle before verify", gap[3], SC);
    chk(gap[1] == 2, "R4 back-to-back poll spacing", gap[1], 2);

    // R4 erase: bit7 reads 0 until 1
    load(16'h0000, 16'h007F, 16'h0080, 16'hFFFF, 16'h0, 4, 16'hFFFF);
    run(22'h3FFFF, 16'hFFFF, 1'b0, 2'd0, 4, 0);
    chk(gap[3] >= SC, "R6 settle before verify (erase)", gap[3], SC);

    // R5 toggle: bit7 irrelevant, stops toggling at read 4
    load(16'h00C0, 16'h0080, 16'h00C0, 16'h0040, 16'hABCD, 5, 16'hABCD);
    run(22'h01234, 16'hABCD, 1'b1, 2'd0, 5, 0);
    chk(gap[4] >= SC, "R6 settle in toggle mode", gap[4], SC);

    // R8 verify mismatch, both confirmations good -> done
    load(16'h0000, 16'h0001, 16'h5A5A, 16'h5A5A, 16'h0, 4, 16'h0000);
    run(22'h00100, 16'h5A5A, 1'b0, 2'd0, 4, 0);

    // R8 second confirmation bad -> error
    load(16'h0000, 16'h0001, 16'h5A5A, 16'h0002, 16'h0, 4, 16'h5A5A);
    run(22'h00200, 16'h5A5A, 1'b0, 2'd1, 4, 0);

    // R8 first confirmation bad -> error at once
    load(16'h0000, 16'h0003, 16'h0004, 16'h5A5A, 16'h0, 4, 16'h5A5A);
    run(22'h00300, 16'h5A5A, 1'b0, 2'd1, 3, 0);

    // R9 timeout in complement mode
    load(16'h0080, 16'h0080, 16'h0080, 16'h0080, 16'h0080, 5, 16'h0080);
    run(22'h00400, 16'h0000, 1'b0, 2'd2, MP, 0);

    // R9 timeout in toggle mode (bit6 keeps alternating)
    load(16'h0040, 16'h0000, 16'h0040, 16'h0000, 16'h0040, 6, 16'h0000);
    script[5] = 16'h0000;
    run(22'h00500, 16'h0000, 1'b1, 2'd2, MP, 0);

    // R2 start while busy is ignored
    load(16'h0080, 16'h0080, 16'h0080, 16'h0080, 16'h1111, 5, 16'h1111);
    run(22'h02468, 16'h1111, 1'b0, 2'd0, 6, 1);

    summary();
    $finish;
  end
endmodule